// File: doc/BRIEF.md
# Receive Sampling Delay Calibrator

This block picks a receive sampling delay for a card-interface host controller. After a one-cycle start pulse it visits every delay tap from 0 up to the sweep length minus one. At each tap it drives the tap onto its delay output and raises a test request. An external requester runs one test transfer at that delay and returns a single result pulse with a pass bit. A pass bit of 1 means the transfer's CRC checked good. The block records every result in a pass bitmap.

While the sweep runs, the block tracks the longest unbroken run of passing taps. No second pass over the bitmap is needed. When the last tap has reported, the block raises done and drives the centre of that run onto the delay output. It also reports the run length and the full bitmap. If no tap passed, it raises a fail flag. The sweep covers 32 or 64 taps. The default follows the kind of target: 32 for embedded memory devices and 64 for removable or I/O cards. A force input can override that default.

Top module: `tap_window_cal`

## Requirements
- R1: A start pulse seen while idle or done clears the bitmap, run length and done. The next cycle shows delay_tap = 0 with test_req high.
- R2: While test_req is high and res_valid is low, test_req stays high and delay_tap holds. Once a result is accepted, test_req drops for exactly one cycle and then rises again with delay_tap one higher.
- R3: pass_map bit t holds res_pass from tap t, with 1 meaning pass and tap 0 at bit 0. Bits at or above the sweep length are 0 after every sweep.
- R4: The sweep length is sampled at start. cfg_force = 1 selects it directly: cfg_force_long = 1 gives 64 taps and 0 gives 32. Otherwise cfg_card = 0 (embedded memory) gives 32 taps and cfg_card = 1 (removable or I/O card) gives 64.
- R5: done rises in the cycle after the last tap's result is accepted. It stays high until the next start, and test_req stays low in that time.
- R6: When done is high and fail is low, run_len gives the length of the longest contiguous run of 1s in pass_map. delay_tap gives that run's start tap plus run_len/2 (rounded down). For example, 0xFFFFFFC0 over 32 taps gives run_len 26 and tap 19, and 0xFFFFFFFFFFFF003F over 64 taps gives run_len 48 and tap 40.
- R7: Among runs of equal longest length, the run with the lowest start tap is chosen.
- R8: A run does not wrap from the highest swept tap to tap 0.
- R9: If no tap passes, done and fail are both high, with delay_tap = 0 and run_len = 0.
- R10: res_valid pulses while test_req is low have no effect on pass_map, run_len, done or delay_tap.
- R11: A start pulse during a sweep is ignored, and the sweep completes as if it had not occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a calibration sweep |
| cfg_card | input | 1 | Target kind: 0 embedded memory (32 taps), 1 removable or I/O card (64 taps) |
| cfg_force | input | 1 | 1 overrides the target-kind default sweep length |
| cfg_force_long | input | 1 | Forced length when cfg_force is 1: 1 gives 64 taps, 0 gives 32 |
| test_req | output | 1 | Request for one test transfer at the current delay_tap |
| res_valid | input | 1 | Result pulse from the requester, accepted while test_req is high |
| res_pass | input | 1 | Result bit: 1 means the CRC was good, 0 means a CRC error |
| delay_tap | output | 6 | Delay tap under test during a sweep; the selected tap once done |
| pass_map | output | 64 | Per-tap pass bitmap, bit index equal to tap number |
| run_len | output | 7 | Length of the longest pass run found |
| done | output | 1 | Calibration finished; held until the next start |
| fail | output | 1 | High with done when no tap passed |

## Verification
Suppose the tap counter or the latched sweep length goes wrong. At the ports the requester then sees a delay_tap that differs from its own tap count on the very next request, or done arrives too early or too late by whole taps. A corrupted run tracker shows nothing until done. Then run_len or delay_tap differs from a plain scan of pass_map, and that scan is computed in a different way from the incremental hardware. Ties, runs placed against either end of the sweep, an all-fail map and an all-pass map are the patterns that set a wrong comparison or a wrapped run apart from the correct one.

// File: rtl/tap_cal_pkg.sv
package tap_cal_pkg;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_PROBE = 2'd1,
    SW_GAP   = 2'd2,
    SW_DONE  = 2'd3
  } sweep_state_t;

  // Centre of a run: its first tap plus half its length, rounded down.
  function automatic int unsigned run_centre(input int unsigned first_tap,
                                             input int unsigned len);
    return first_tap + (len >> 1);
  endfunction

  // Sweep length chosen from target kind, with an optional forced choice.
  function automatic int unsigned pick_taps(input logic card, input logic force_en,
                                            input logic force_long,
                                            input int unsigned short_n,
                                            input int unsigned long_n);
    logic use_long;
    use_long = force_en ? force_long : card;
    return use_long ? long_n : short_n;
  endfunction

endpackage

// File: rtl/tap_len_select.sv
module tap_len_select #(
  parameter int SHORT_TAPS = 32,
  parameter int LONG_TAPS  = 64,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             cfg_card,
  input  logic             cfg_force,
  input  logic             cfg_force_long,
  output logic [CNT_W-1:0] sweep_cnt
);
  import tap_cal_pkg::*;

  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    cnt_next = CNT_W'(pick_taps(cfg_card, cfg_force, cfg_force_long,
                                SHORT_TAPS, LONG_TAPS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sweep_cnt <= CNT_W'(SHORT_TAPS);
    else if (load) sweep_cnt <= cnt_next;
  end

  // R4
  len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_cnt == CNT_W'(SHORT_TAPS)) || (sweep_cnt == CNT_W'(LONG_TAPS)));

  // R4
  len_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sweep_cnt));

endmodule

// File: rtl/tap_sweep_ctrl.sv
module tap_sweep_ctrl #(
  parameter int TAP_W = 6,
  parameter int CNT_W = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [CNT_W-1:0]          sweep_cnt,
  input  logic                      res_valid,
  output tap_cal_pkg::sweep_state_t state,
  output logic [TAP_W-1:0]          tap,
  output logic                      test_req,
  output logic                      clear_ev,
  output logic                      accept_ev,
  output logic                      finish_ev
);
  import tap_cal_pkg::*;

  sweep_state_t state_nx;
  logic         last_tap;

  always_comb begin
    clear_ev  = start && (state == SW_IDLE || state == SW_DONE);
    accept_ev = (state == SW_PROBE) && res_valid;
    last_tap  = (CNT_W'(tap) == (sweep_cnt - 1'b1));
    finish_ev = accept_ev && last_tap;
    test_req  = (state == SW_PROBE);
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      SW_IDLE:  if (clear_ev) state_nx = SW_PROBE;
      SW_PROBE: if (accept_ev) state_nx = last_tap ? SW_DONE : SW_GAP;
      SW_GAP:   state_nx = SW_PROBE;
      SW_DONE:  if (clear_ev) state_nx = SW_PROBE;
      default:  state_nx = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SW_IDLE;
      tap   <= '0;
    end else begin
      state <= state_nx;
      if (clear_ev)                   tap <= '0;
      else if (accept_ev && !last_tap) tap <= tap + 1'b1;
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_req && !res_valid |=> test_req && $stable(tap));

  // R2
  gap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == SW_GAP |-> !test_req && (tap == $past(tap) + 1'b1));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == SW_DONE && !start |=> state == SW_DONE);

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && state == SW_PROBE && !res_valid |=> state == SW_PROBE && $stable(tap));

endmodule

// File: rtl/tap_pass_map.sv
module tap_pass_map #(
  parameter int MAX_TAPS = 64,
  parameter int TAP_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_ev,
  input  logic                accept_ev,
  input  logic [TAP_W-1:0]    tap,
  input  logic                pass_bit,
  output logic [MAX_TAPS-1:0] pass_map
);

  for (genvar g = 0; g < MAX_TAPS; g++) begin : g_bit
    logic hit;
    assign hit = accept_ev && (tap == TAP_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pass_map[g] <= 1'b0;
      else if (clear_ev) pass_map[g] <= 1'b0;
      else if (hit)      pass_map[g] <= pass_bit;
    end
  end

  // R10
  map_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_ev && !clear_ev |=> $stable(pass_map));

  // R3
  map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev && !clear_ev |=> pass_map[$past(tap)] == $past(pass_bit));

endmodule

// File: rtl/tap_run_tracker.sv
module tap_run_tracker #(
  parameter int TAP_W = 6,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_ev,
  input  logic             accept_ev,
  input  logic [TAP_W-1:0] tap,
  input  logic             pass_bit,
  output logic [TAP_W-1:0] best_start,
  output logic [LEN_W-1:0] best_len
);

  logic [TAP_W-1:0] cur_start, run_first;
  logic [LEN_W-1:0] cur_len, run_len_nx;
  logic             beats_best;

  always_comb begin
    run_first  = (cur_len == '0) ? tap : cur_start;
    run_len_nx = cur_len + 1'b1;
    // Strict compare: an equal later run never displaces an earlier one.
    beats_best = accept_ev && pass_bit && (run_len_nx > best_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_start  <= '0;
      cur_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
    end else if (clear_ev) begin
      cur_start  <= '0;
      cur_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
    end else if (accept_ev) begin
      if (pass_bit) begin
        cur_start <= run_first;
        cur_len   <= run_len_nx;
      end else begin
        cur_len   <= '0;
      end
      if (beats_best) begin
        best_start <= run_first;
        best_len   <= run_len_nx;
      end
    end
  end

  // R6
  best_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_ev |=> best_len >= $past(best_len));

  // R8
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |-> ({1'b0, cur_len} <= (LEN_W + 1)'(tap)));

endmodule

// File: rtl/tap_window_cal.sv
module tap_window_cal #(
  parameter int MAX_TAPS   = 64,
  parameter int SHORT_TAPS = 32,
  parameter int TAP_W      = $clog2(MAX_TAPS),
  parameter int LEN_W      = $clog2(MAX_TAPS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cfg_card,
  input  logic                cfg_force,
  input  logic                cfg_force_long,
  output logic                test_req,
  input  logic                res_valid,
  input  logic                res_pass,
  output logic [TAP_W-1:0]    delay_tap,
  output logic [MAX_TAPS-1:0] pass_map,
  output logic [LEN_W-1:0]    run_len,
  output logic                done,
  output logic                fail
);
  import tap_cal_pkg::*;

  sweep_state_t     state;
  logic [LEN_W-1:0] sweep_cnt;
  logic [TAP_W-1:0] tap;
  logic             clear_ev, accept_ev, finish_ev;
  logic [TAP_W-1:0] best_start;
  logic [LEN_W-1:0] best_len;
  logic [TAP_W-1:0] centre_tap;

  tap_len_select #(.SHORT_TAPS(SHORT_TAPS), .LONG_TAPS(MAX_TAPS), .CNT_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .load(clear_ev),
    .cfg_card(cfg_card), .cfg_force(cfg_force), .cfg_force_long(cfg_force_long),
    .sweep_cnt(sweep_cnt)
  );

  tap_sweep_ctrl #(.TAP_W(TAP_W), .CNT_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sweep_cnt(sweep_cnt),
    .res_valid(res_valid), .state(state), .tap(tap), .test_req(test_req),
    .clear_ev(clear_ev), .accept_ev(accept_ev), .finish_ev(finish_ev)
  );

  tap_pass_map #(.MAX_TAPS(MAX_TAPS), .TAP_W(TAP_W)) u_map (
    .clk(clk), .rst_n(rst_n), .clear_ev(clear_ev), .accept_ev(accept_ev),
    .tap(tap), .pass_bit(res_pass), .pass_map(pass_map)
  );

  tap_run_tracker #(.TAP_W(TAP_W), .LEN_W(LEN_W)) u_run (
    .clk(clk), .rst_n(rst_n), .clear_ev(clear_ev), .accept_ev(accept_ev),
    .tap(tap), .pass_bit(res_pass), .best_start(best_start), .best_len(best_len)
  );

  always_comb begin
    centre_tap = TAP_W'(run_centre(32'(best_start), 32'(best_len)));
    done       = (state == SW_DONE);
    fail       = done && (best_len == '0);
    run_len    = best_len;
    unique case (state)
      SW_PROBE, SW_GAP: delay_tap = tap;
      SW_DONE:          delay_tap = fail ? '0 : centre_tap;
      default:          delay_tap = '0;
    endcase
  end

  // R5
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ev |=> done && !test_req);

  // R6
  pick_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fail |-> pass_map[delay_tap]);

  // R3
  len_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_len <= sweep_cnt);

  // R9
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> pass_map == '0);

endmodule

// File: tb/tap_window_cal_test.sv
module tap_window_cal_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_card = 1'b0, cfg_force = 1'b0, cfg_force_long = 1'b0;
  logic        res_valid = 1'b0, res_pass = 1'b0;
  logic        test_req, done, fail;
  logic [5:0]  delay_tap;
  logic [63:0] pass_map;
  logic [6:0]  run_len;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  tap_window_cal uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_card(cfg_card),
    .cfg_force(cfg_force), .cfg_force_long(cfg_force_long),
    .test_req(test_req), .res_valid(res_valid), .res_pass(res_pass),
    .delay_tap(delay_tap), .pass_map(pass_map), .run_len(run_len),
    .done(done), .fail(fail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Reference: scan every run start and measure forward; no wrap.
  task automatic ref_pick(input logic [63:0] m, input int n,
                          output int best_len, output int best_tap);
    best_len = 0; best_tap = 0;
    for (int i = 0; i < n; i++) begin
      if (m[i] && (i == 0 || !m[i-1])) begin
        int j = i;
        while (j < n && m[j]) j++;
        if (j - i > best_len) begin
          best_len = j - i;
          best_tap = i + (j - i) / 2;
        end
      end
    end
  endtask

  task automatic begin_sweep(input logic card, input logic fen, input logic flong,
                             input string tag);
    cfg_card = card; cfg_force = fen; cfg_force_long = flong;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: sweep opens at tap 0 with a live request and clean results
    chk(test_req == 1'b1, "R1", {tag, " req after start"}, 64'(test_req), 64'd1);
    chk(delay_tap == 6'd0, "R1", {tag, " tap after start"}, 64'(delay_tap), 64'd0);
    chk(done == 1'b0 && pass_map == '0 && run_len == '0, "R1",
        {tag, " cleared"}, pass_map, 64'd0);
  endtask

  // Requester model: serves n taps, optionally pokes start mid-sweep.
  task automatic serve(input logic [63:0] m, input int n, input bit poke,
                       input string tag);
    for (int t = 0; t < n; t++) begin
      int guard = 0;
      while (!test_req && guard < 20) begin @(negedge clk); guard++; end
      chk(test_req && delay_tap == 6'(t), "R2", {tag, " tap order"},
          64'(delay_tap), 64'(t));
      for (int w = 0; w < t % 3; w++) begin
        if (poke && t == 5 && w == 0) start = 1'b1;  // R11
        @(negedge clk);
        start = 1'b0;
        chk(test_req && delay_tap == 6'(t), "R2", {tag, " hold while waiting"},
            64'(delay_tap), 64'(t));
      end
      res_valid = 1'b1; res_pass = m[t];
      @(negedge clk);
      res_valid = 1'b0; res_pass = 1'b0;
      if (t < n - 1)
        chk(!test_req && !done, "R2", {tag, " one-cycle gap"}, 64'(test_req), 64'd0);
    end
  endtask

  task automatic finish_check(input logic [63:0] m, input int n, input string req,
                              input string tag);
    logic [63:0] mm;
    int el, et;
    mm = (n == 64) ? m : (m & ((64'd1 << n) - 1));
    ref_pick(mm, n, el, et);
    chk(done == 1'b1 && test_req == 1'b0, "R5", {tag, " done after last tap"},
        64'(done), 64'd1);
    chk(pass_map == mm, "R3", {tag, " bitmap"}, pass_map, mm);
    chk(run_len == 7'(el), req, {tag, " run length"}, 64'(run_len), 64'(el));
    chk(delay_tap == 6'(et), req, {tag, " selected tap"}, 64'(delay_tap), 64'(et));
    chk(fail == (el == 0), "R9", {tag, " fail flag"}, 64'(fail), 64'(el == 0));
    repeat (3) @(negedge clk);
    chk(done && !test_req && delay_tap == 6'(et), "R5", {tag, " done held"},
        64'(delay_tap), 64'(et));
  endtask

  task automatic do_cal(input logic card, input logic fen, input logic flong,
                        input logic [63:0] m, input int n, input bit poke,
                        input string req, input string tag);
    begin_sweep(card, fen, flong, tag);
    serve(m, n, poke, tag);
    finish_check(m, n, req, tag);
  endtask

  task automatic test_reset;
    chk(!done && !test_req && !fail && delay_tap == 0 && pass_map == 0,
        "R1", "reset state", pass_map, 64'd0);
  endtask

  task automatic test_stray;
    logic [63:0] m0;
    logic [6:0]  l0;
    logic [5:0]  t0;
    m0 = pass_map; l0 = run_len; t0 = delay_tap;
    res_valid = 1'b1; res_pass = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; res_pass = 1'b0;
    @(negedge clk);
    chk(pass_map == m0 && run_len == l0 && delay_tap == t0 && done, "R10",
        "stray result ignored", pass_map, m0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    // R4 / R6: embedded-memory default of 32 taps, worked example
    do_cal(1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFC0, 32, 1'b0, "R6", "R4 card0 32");
    // R4 / R6: card default of 64 taps, worked example
    do_cal(1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_003F, 64, 1'b0, "R6", "R4 card1 64");
    // R4: forced long on an embedded target
    do_cal(1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFC_07FF, 64, 1'b0, "R6", "R4 force64");
    // R4 / R3: forced short on a card target; upper bits must clear
    do_cal(1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_0FFC_07FF, 32, 1'b0, "R6", "R4 force32");
    // R7: equal runs, lower start wins
    do_cal(1'b0, 1'b0, 1'b0, 64'h0000_0000_00F0_00F0, 32, 1'b0, "R7", "R7 tie");
    // R8: runs at both ends do not join
    do_cal(1'b0, 1'b0, 1'b0, 64'h0000_0000_F000_000F, 32, 1'b0, "R8", "R8 nowrap");
    // R9: nothing passes
    do_cal(1'b1, 1'b0, 1'b0, 64'h0, 64, 1'b0, "R9", "R9 allfail");
    // R10: result pulses while not requesting
    test_stray();
    // R6: every tap passes
    do_cal(1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64, 1'b0, "R6", "R6 allpass");
    // R8: single pass at the top tap
    do_cal(1'b1, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 64, 1'b0, "R8", "R8 toptap");
    // R11: start pulse in the middle of a sweep
    do_cal(1'b0, 1'b0, 1'b0, 64'h0000_0000_3C3F_F0F1, 32, 1'b1, "R11", "R11 busy start");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule